// File: doc/BRIEF.md
# Descriptor Ownership Walker for One DMA Channel

This block steps through a ring of two-dword message descriptors that serves one channel in one direction. Each entry holds a control word at byte offset 0 and a data buffer pointer at byte offset 4. The walker first fetches the control word and tests its ownership flag. If the flag hands the entry to the walker, it fetches the pointer and passes the pointer and the buffer length to an external data mover. It then waits for the mover to report that the buffer is complete.

When the mover finishes, the walker can write a status word back over the control word, if the channel allows it. The status word returns ownership to the host and records the byte count and the end-of-message flag. In ECC mode the pointer it read earlier is written back with the status word, so every write is one full 64-bit transaction. A message may span several consecutive entries. Entries are always handled in table order, and the index wraps at a configurable table size.

An entry the host still owns is handled in one of three ways. With polling enabled, the walker re-reads the entry until the host grants it. With polling disabled in the middle of a message, the walker raises an ownership interrupt and halts. With polling disabled between messages, it goes idle without an interrupt. A start pulse resumes the walk from the same entry in both the halted and the idle case.

Top module: `desc_own_engine`

## Requirements
- R1: After reset the block is idle and not halted. mem_req, mv_start and own_irq are all low.
- R2: The first start pulse after reset loads the entry index from cfg_first_idx. The control word of entry i is read at cfg_base + 8*i. In the control word, bit 31 is the ownership flag (1 = owned by the block), bit 30 is end-of-message, and bits 15:0 are the buffer length.
- R3: For an owned entry, the block reads the pointer at cfg_base + 8*i + 4. It then raises mv_start for exactly one cycle, with mv_ptr equal to that pointer and mv_len equal to bits 15:0 of the control word.
- R4: With cfg_poll_en = 1, an entry with bit 31 clear is read again and again until bit 31 is set. Meanwhile busy stays high and own_irq stays low.
- R5: With cfg_poll_en = 0, an unowned entry met while a message is in progress (the last completed buffer reported mv_eom = 0) pulses own_irq for one cycle. The block then stays halted and issues no memory request until start.
- R6: With cfg_poll_en = 0, an unowned entry met between messages sends the block idle, with no interrupt and no halt.
- R7: With cfg_wb_en = 0, no memory write occurs and every control word stays unchanged.
- R8: With cfg_wb_en = 1 and cfg_ecc_en = 0, each completed buffer causes one 32-bit write (mem_wide = 0) at the control word address. The value written is bit 31 = 0, bit 30 = mv_eom, bits 29:16 = 0 and bits 15:0 = mv_count.
- R9: With cfg_wb_en = 1 and cfg_ecc_en = 1, the write is a single 64-bit write (mem_wide = 1) at the control word address. mem_wdata[31:0] carries the status word and mem_wdata[63:32] carries the pointer that was read.
- R10: Entries are processed strictly in order. The index advances by one after each completed buffer (after its write, if any) and wraps to 0 after entry cfg_entries-1. cur_idx shows the entry where the walk stopped.
- R11: A memory request keeps mem_req high and mem_addr and mem_we unchanged until mem_ack.
- R12: A start pulse while halted or idle resumes the walk at the same entry, with the in-message state cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that starts or resumes the walk |
| cfg_base | input | AW | Byte address of entry 0 |
| cfg_first_idx | input | IDX_W | Entry used by the first start after reset |
| cfg_entries | input | IDX_W+1 | Number of entries in the ring (1 to 2^IDX_W) |
| cfg_poll_en | input | 1 | Re-read unowned entries |
| cfg_wb_en | input | 1 | Write a status word after each buffer |
| cfg_ecc_en | input | 1 | Make every write 64 bits wide |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_wide | output | 1 | Write covers both dwords |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 64 | Write data, low dword at mem_addr |
| mem_ack | input | 1 | Request accepted and completed this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mv_start | output | 1 | One-cycle pulse that launches the data mover |
| mv_ptr | output | 32 | Buffer pointer for the mover |
| mv_len | output | 16 | Buffer length for the mover |
| mv_done | input | 1 | Mover completion pulse |
| mv_count | input | 16 | Bytes moved, valid with mv_done |
| mv_eom | input | 1 | Buffer ended a message, valid with mv_done |
| busy | output | 1 | Walk in progress |
| halted | output | 1 | Stopped on an ownership error |
| own_irq | output | 1 | One-cycle ownership error pulse |
| cur_idx | output | IDX_W | Current entry index |

## Verification
The hardest state to reach is a poll that must end in a halt rather than an idle stop. This needs a message left open by mover reports, then an unowned terminal entry, then polling switched off while the block is spinning on that entry. The bench builds random rings in which the host grants some unowned entries only after a random number of reads. It runs them until every expected buffer has moved and the terminal entry has been re-read several times. It then clears cfg_poll_en and compares the resulting halt or idle state, the interrupt count and the final table against a walk computed in the bench. A halt followed by a resume from the same entry is also driven directly.

// File: rtl/desc_own_engine.sv
module desc_own_engine #(
  parameter int AW    = 32,
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    cfg_base,
  input  logic [IDX_W-1:0] cfg_first_idx,
  input  logic [IDX_W:0]   cfg_entries,
  input  logic             cfg_poll_en,
  input  logic             cfg_wb_en,
  input  logic             cfg_ecc_en,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_wide,
  output logic [AW-1:0]    mem_addr,
  output logic [63:0]      mem_wdata,
  input  logic             mem_ack,
  input  logic [31:0]      mem_rdata,
  output logic             mv_start,
  output logic [31:0]      mv_ptr,
  output logic [15:0]      mv_len,
  input  logic             mv_done,
  input  logic [15:0]      mv_count,
  input  logic             mv_eom,
  output logic             busy,
  output logic             halted,
  output logic             own_irq,
  output logic [IDX_W-1:0] cur_idx
);

  localparam int OWN_BIT = 31;
  localparam int EOM_BIT = 30;
  localparam int ENT_SH  = 3;

  typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_XFER, S_WB, S_HALT} st_t;

  st_t              st;
  logic [IDX_W-1:0] idx;
  logic             loaded;
  logic             in_msg;
  logic [31:0]      ptr_q;
  logic [15:0]      len_q;
  logic [31:0]      stat_q;

  logic [AW-1:0]    ent_addr;
  logic [IDX_W-1:0] idx_nxt;
  logic [IDX_W:0]   idx_inc;

  assign ent_addr = cfg_base + AW'({idx, {ENT_SH{1'b0}}});
  assign idx_inc  = {1'b0, idx} + (IDX_W+1)'(1);
  assign idx_nxt  = (idx_inc == cfg_entries) ? '0 : idx_inc[IDX_W-1:0];

  assign mem_req   = (st == S_RD0) || (st == S_RD1) || (st == S_WB);
  assign mem_we    = (st == S_WB);
  assign mem_wide  = (st == S_WB) && cfg_ecc_en;
  assign mem_addr  = (st == S_RD1) ? ent_addr + AW'(4) : ent_addr;
  assign mem_wdata = {cfg_ecc_en ? ptr_q : 32'h0, stat_q};

  assign mv_ptr  = ptr_q;
  assign mv_len  = len_q;
  assign busy    = (st != S_IDLE) && (st != S_HALT);
  assign halted  = (st == S_HALT);
  assign cur_idx = idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      loaded   <= 1'b0;
      in_msg   <= 1'b0;
      ptr_q    <= '0;
      len_q    <= '0;
      stat_q   <= '0;
      mv_start <= 1'b0;
      own_irq  <= 1'b0;
    end else begin
      mv_start <= 1'b0;
      own_irq  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (!loaded) begin
            idx    <= cfg_first_idx;
            loaded <= 1'b1;
          end
          in_msg <= 1'b0;
          st     <= S_RD0;
        end
        S_HALT: if (start) begin
          in_msg <= 1'b0;
          st     <= S_RD0;
        end
        S_RD0: if (mem_ack) begin
          if (mem_rdata[OWN_BIT]) begin
            len_q <= mem_rdata[15:0];
            st    <= S_RD1;
          end else if (cfg_poll_en) begin
            st <= S_RD0;
          end else if (in_msg) begin
            own_irq <= 1'b1;
            st      <= S_HALT;
          end else begin
            st <= S_IDLE;
          end
        end
        S_RD1: if (mem_ack) begin
          ptr_q    <= mem_rdata;
          mv_start <= 1'b1;
          st       <= S_XFER;
        end
        S_XFER: if (mv_done) begin
          stat_q <= {1'b0, mv_eom, 14'h0, mv_count};
          in_msg <= !mv_eom;
          if (cfg_wb_en) begin
            st <= S_WB;
          end else begin
            idx <= idx_nxt;
            st  <= S_RD0;
          end
        end
        S_WB: if (mem_ack) begin
          idx <= idx_nxt;
          st  <= S_RD0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R5
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_req && !mv_start));

  // R5
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_irq |=> (!own_irq && halted));

  // R7
  wb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> cfg_wb_en);

  // R8
  narrow_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !cfg_ecc_en) |-> (!mem_wide && !mem_wdata[OWN_BIT]));

  // R9
  ecc_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && cfg_ecc_en) |-> (mem_wide && mem_wdata[63:32] == mv_ptr));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R3
  mv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |=> !mv_start);

endmodule

// File: tb/tb_desc_own_engine.sv
module tb_desc_own_engine;
  localparam int AW = 32;
  localparam int IDX_W = 12;
  localparam int NT = 16;
  localparam logic [31:0] BASE = 32'h0000_4000;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] cfg_base = BASE;
  logic [IDX_W-1:0] cfg_first_idx = '0;
  logic [IDX_W:0] cfg_entries = 13'd4;
  logic cfg_poll_en = 0, cfg_wb_en = 0, cfg_ecc_en = 0;
  logic mem_req, mem_we, mem_wide, mem_ack = 0;
  logic [AW-1:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic mv_start, mv_done = 0, mv_eom = 0;
  logic [31:0] mv_ptr;
  logic [15:0] mv_len, mv_count = '0;
  logic busy, halted, own_irq;
  logic [IDX_W-1:0] cur_idx;

  desc_own_engine #(.AW(AW), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
    .cfg_first_idx(cfg_first_idx), .cfg_entries(cfg_entries),
    .cfg_poll_en(cfg_poll_en), .cfg_wb_en(cfg_wb_en), .cfg_ecc_en(cfg_ecc_en),
    .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mv_start(mv_start), .mv_ptr(mv_ptr), .mv_len(mv_len), .mv_done(mv_done),
    .mv_count(mv_count), .mv_eom(mv_eom), .busy(busy), .halted(halted),
    .own_irq(own_irq), .cur_idx(cur_idx));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  logic [31:0] m_d0[NT], m_d1[NT], i_d0[NT], e_d0[NT];
  int grant_after[NT];
  logic [15:0] mc_cnt[NT];
  bit mc_eom[NT];
  int a_idx[64];
  logic [15:0] a_len[64];
  int n_xfer = 0, irq_cnt = 0, rd0_cnt = 0, wr_cnt = 0;
  int e_seq[64];
  logic [15:0] e_len[64];
  int e_n, e_end;
  bit e_halt;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // memory responder, R11 hold check
  initial begin
    int off, ix;
    bit pend;
    logic [AW-1:0] paddr;
    pend = 0; paddr = '0;
    forever begin
      @(negedge clk);
      mem_ack = 0;
      if (pend && rst_n) chk(mem_req && mem_addr == paddr, "R11", "request held", mem_addr, paddr);
      pend = 0;
      if (mem_req && rst_n) begin
        if ($urandom % 4 != 0) begin
          off = int'(mem_addr - BASE);
          ix = off >> 3;
          mem_ack = 1;
          if (ix < 0 || ix >= NT) begin
            chk(0, "R2", "address in table", mem_addr, BASE);
            ix = 0;
          end
          if (!mem_we) begin
            if (off[2]) mem_rdata = m_d1[ix];
            else begin
              mem_rdata = m_d0[ix];
              rd0_cnt++;
              if (!m_d0[ix][31] && cfg_poll_en && grant_after[ix] > 0) begin
                grant_after[ix]--;
                if (grant_after[ix] == 0) m_d0[ix][31] = 1'b1;
              end
            end
          end else begin
            wr_cnt++;
            chk(cfg_wb_en, "R7", "write with writeback off", 1, 0);
            chk(off[2] == 1'b0, "R8", "write at control word", off, ix * 8);
            if (cfg_ecc_en) begin
              chk(mem_wide, "R9", "wide write", mem_wide, 1);
              chk(mem_wdata[63:32] == m_d1[ix], "R9", "pointer dword", mem_wdata[63:32], m_d1[ix]);
            end else
              chk(!mem_wide, "R8", "narrow write", mem_wide, 0);
            m_d0[ix] = mem_wdata[31:0];
          end
        end else begin
          pend = 1; paddr = mem_addr;
        end
      end
    end
  end

  // data mover model
  initial begin
    int wt, cur;
    wt = -1; cur = 0;
    forever begin
      @(negedge clk);
      mv_done = 0;
      if (mv_start && wt < 0) begin
        cur = int'((mv_ptr >> 4) & 32'hF);
        if (n_xfer < 64) begin
          a_idx[n_xfer] = cur;
          a_len[n_xfer] = mv_len;
        end
        n_xfer++;
        rd0_cnt = 0;
        wt = $urandom % 4;
      end
      if (wt == 0) begin
        mv_done = 1; mv_count = mc_cnt[cur]; mv_eom = mc_eom[cur]; wt = -1;
      end else if (wt > 0) wt--;
    end
  end

  initial forever begin
    @(negedge clk);
    if (own_irq) irq_cnt++;
  end

  task automatic ref_walk(input int first, input int size, input bit poll, input bit wb);
    logic [31:0] w[NT];
    int g[NT];
    int idx;
    bit inm;
    for (int i = 0; i < NT; i++) begin w[i] = m_d0[i]; g[i] = grant_after[i]; end
    idx = first; inm = 0; e_n = 0;
    for (int s = 0; s < 60; s++) begin
      if (!(w[idx][31] || (poll && g[idx] > 0))) break;
      w[idx][31] = 1'b1; g[idx] = 0;
      e_seq[e_n] = idx; e_len[e_n] = w[idx][15:0]; e_n++;
      if (wb) w[idx] = {1'b0, mc_eom[idx], 14'h0, mc_cnt[idx]};
      inm = !mc_eom[idx];
      idx = (idx + 1 == size) ? 0 : idx + 1;
    end
    e_halt = inm; e_end = idx;
    for (int i = 0; i < NT; i++) e_d0[i] = w[i];
  endtask

  task automatic do_reset();
    rst_n = 0; start = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !halted, "R1", "idle after reset", {busy, halted}, 0);
    chk(!mem_req && !mv_start && !own_irq, "R1", "quiet after reset", {mem_req, mv_start, own_irq}, 0);
  endtask

  task automatic run_case(input string tag, input bit rst, input int first, input int size,
                          input bit poll, input bit wb, input bit ecc);
    int cyc;
    bit dropped;
    if (rst) do_reset();
    cfg_first_idx = IDX_W'(first); cfg_entries = (IDX_W+1)'(size);
    cfg_poll_en = poll; cfg_wb_en = wb; cfg_ecc_en = ecc;
    for (int i = 0; i < NT; i++) i_d0[i] = m_d0[i];
    ref_walk(first, size, poll, wb);
    n_xfer = 0; irq_cnt = 0; rd0_cnt = 0; wr_cnt = 0; dropped = 0;
    start = 1; @(negedge clk); start = 0;
    for (cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (poll && !dropped && n_xfer == e_n && rd0_cnt >= 3) begin
        chk(busy && irq_cnt == 0, "R4", {tag, " polling keeps busy"}, {busy, irq_cnt[7:0]}, 9'h100);
        cfg_poll_en = 0; dropped = 1;
      end
      if (!busy) break;
    end
    repeat (2) @(negedge clk);
    chk(halted == e_halt, e_halt ? "R5" : "R6", {tag, " halted"}, halted, e_halt);
    chk(irq_cnt == (e_halt ? 1 : 0), e_halt ? "R5" : "R6", {tag, " irq count"}, irq_cnt, e_halt ? 1 : 0);
    chk(n_xfer == e_n, "R10", {tag, " buffer count"}, n_xfer, e_n);
    for (int k = 0; k < e_n && k < n_xfer; k++) begin
      chk(a_idx[k] == e_seq[k], k == 0 ? "R2" : "R10", {tag, " entry order"}, a_idx[k], e_seq[k]);
      chk(a_len[k] == e_len[k], "R3", {tag, " length"}, a_len[k], e_len[k]);
    end
    chk(int'(cur_idx) == e_end, "R10", {tag, " stop index"}, cur_idx, e_end);
    chk(wr_cnt == (wb ? e_n : 0), wb ? "R8" : "R7", {tag, " write count"}, wr_cnt, wb ? e_n : 0);
    for (int i = 0; i < NT; i++)
      chk(m_d0[i] == e_d0[i], wb ? "R8" : "R7", {tag, " control word"}, m_d0[i], e_d0[i]);
  endtask

  task automatic gen_table(input int size, input bit poll, input bit wb);
    int t;
    for (int i = 0; i < NT; i++) begin
      m_d1[i] = ($urandom & 32'hFFFF_FF00) | (32'(i) << 4);
      m_d0[i] = {1'($urandom % 4 != 0), 1'($urandom), 14'($urandom), 16'($urandom)};
      mc_cnt[i] = 16'($urandom);
      mc_eom[i] = 1'($urandom);
      grant_after[i] = (poll && !m_d0[i][31] && $urandom % 2 == 1) ? 1 + $urandom % 3 : 0;
    end
    if (!wb) begin
      t = $urandom % size;
      m_d0[t][31] = 1'b0; grant_after[t] = 0;
    end
  endtask

  task automatic clear_table();
    for (int i = 0; i < NT; i++) begin
      m_d1[i] = 32'h5000_0000 | (32'(i) << 4);
      m_d0[i] = 32'h0;
      mc_cnt[i] = 16'(i * 3 + 1);
      mc_eom[i] = 1;
      grant_after[i] = 0;
    end
  endtask

  initial begin
    process::self().srandom(32'd1234);
    // R10 wrap: size 3 starting at entry 2
    clear_table();
    for (int i = 0; i < 3; i++) m_d0[i] = 32'h8000_0000 | 32'(16 + i);
    run_case("wrap", 1, 2, 3, 0, 1, 0);
    // R5 halt in mid-message
    clear_table();
    m_d0[0] = 32'h8000_0040; mc_eom[0] = 0;
    run_case("halt", 1, 0, 4, 0, 0, 0);
    // R12 resume from halted entry with message state cleared
    m_d0[1] = 32'hC000_0022; mc_eom[1] = 1;
    run_case("resume", 0, 1, 4, 0, 1, 1);
    chk(mc_eom[1] && !halted, "R12", "resume ends idle", halted, 0);
    // R4 polling with a delayed grant
    clear_table();
    m_d0[1] = 32'h0000_0010; grant_after[1] = 2;
    m_d0[2] = 32'h8000_0011; mc_eom[2] = 0;
    run_case("poll", 1, 1, 4, 1, 1, 1);
    // R6 unowned first entry between messages
    clear_table();
    run_case("idle", 1, 2, 4, 0, 0, 0);
    // R12 resume from idle at the same entry
    m_d0[2] = 32'h8000_0005;
    run_case("idle_resume", 0, 2, 4, 0, 0, 0);
    for (int n = 0; n < 30; n++) begin
      int sz, fi;
      bit p, w, e;
      sz = 2 + $urandom % (NT - 1);
      fi = $urandom % sz;
      p = 1'($urandom); w = 1'($urandom); e = 1'($urandom);
      gen_table(sz, p, w);
      run_case("random", 1, fi, sz, p, w, e);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule